// File: doc/BRIEF.md
# Programmable Integer Clock Divider with Cycle-Step Phase Offset

This block turns a fast input clock into a slower divided waveform, delivered both as a level (`div_clk`) and as a one-cycle strobe (`edge_pulse`) that marks the first high cycle of every divided period. A 3-bit ratio code selects a division of 1 to 8. A second 3-bit code delays the whole divided waveform by 0 to 7 input cycles. Both codes are captured into an active copy only at reset or when the `realign` strobe is sampled high. Changing the code pins therefore never disturbs a waveform already running. A realign restarts the divided period from a known point.

The block also drives a stabilizer request flag, `stab_active`. It is the OR of a user enable bit and a forced term that is true whenever the active ratio is anything other than divide-by-1. The flag is a plain logic signal for whatever duty-cycle circuitry sits downstream.

Top module: `clkdiv_phase_top`

## Requirements
- R1: With active ratio code n, the divided waveform is periodic with period n+1 input cycles, and `edge_pulse` fires once per period. When n is not 0, two consecutive cycles never both carry `edge_pulse`.
- R2: For division N ≥ 2, `div_clk` is high for floor(N/2) cycles and low for the remaining cycles of each period. For N = 1 (code 0), `div_clk` stays high and `edge_pulse` fires every cycle once the waveform has started.
- R3: Take the edge at which a realign or reset is sampled as cycle 0. With active phase code p, `div_clk` and `edge_pulse` are both low in cycles 0 to p. The first high cycle and the first pulse are in cycle p+1.
- R4: `edge_pulse` is high only in cycles where `div_clk` is high, and only in the first high cycle of each divided period.
- R5: Changes on `ratio_code` or `phase_code` have no effect on the outputs, including `stab_active`, until a realign or reset is sampled.
- R6: When `realign` is sampled high, the new ratio and phase codes become active, the period restarts, and both waveform outputs are low in the following cycle.
- R7: While `rst` (synchronous, active high) is sampled high, both waveform outputs are low in the following cycle. The active codes return to 0, which gives divide-by-1 with no delay.
- R8: `stab_active` is high whenever `user_stab_en` is high or the active ratio code is not 0. It is low only when both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| realign | input | 1 | Loads the code pins and restarts the divided period |
| ratio_code | input | 3 | Division minus one (0 gives ÷1, 7 gives ÷8) |
| phase_code | input | 3 | Delay of the divided waveform in input cycles (0 to 7) |
| user_stab_en | input | 1 | User request for the stabilizer flag |
| div_clk | output | 1 | Divided waveform level |
| edge_pulse | output | 1 | One-cycle strobe on the first high cycle of each period |
| stab_active | output | 1 | Stabilizer request: user bit OR active ratio not 0 |

## Verification
Both waveform outputs come from registers, so a realign or reset sampled at one edge shows up as low outputs in the next cycle. The first high cycle is due exactly p+1 cycles after that edge. From then on the level and the strobe follow the period with no added latency. `stab_active` is combinational from the user pin and from the active ratio. It moves in the same cycle as the user pin, and in the cycle after the edge that loads a new ratio. The reference model advances one step per clock edge and is compared with every output at each falling edge, midway between the edges that change the design's state. The checks cover every ratio and phase pair and the cycles after changes that are not yet meant to take effect.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // One sample of the divided waveform: level and start-of-period strobe.
    typedef struct packed {
        logic lvl;
        logic edg;
    } wave_t;

    localparam wave_t WAVE_IDLE = '{lvl: 1'b0, edg: 1'b0};

    // Number of high cycles per period for a ratio code (division = code + 1).
    function automatic int unsigned high_cycles(input int unsigned code);
        return (code + 1) / 2;
    endfunction

endpackage

// File: rtl/clkdiv_cfg_hold.sv
module clkdiv_cfg_hold #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              realign,
    input  logic [CODE_W-1:0] ratio_in,
    input  logic [CODE_W-1:0] phase_in,
    output logic [CODE_W-1:0] ratio_act,
    output logic [CODE_W-1:0] phase_act
);

    // Active copies change only at reset or realign.
    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_act <= '0;
            phase_act <= '0;
        end else if (realign) begin
            ratio_act <= ratio_in;
            phase_act <= phase_in;
        end
    end

endmodule

// File: rtl/clkdiv_count.sv
module clkdiv_count
    import clkdiv_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              realign,
    input  logic [CODE_W-1:0] ratio_act,
    output wave_t             base
);

    localparam int CW1 = CODE_W + 1;

    logic [CODE_W-1:0] cnt_q;
    logic [CW1-1:0]    high_len;

    always_ff @(posedge clk) begin
        if (rst || realign) begin
            cnt_q <= '0;
        end else if (cnt_q == ratio_act) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        high_len = CW1'(high_cycles(32'(ratio_act)));
        base.edg = (cnt_q == '0);
        if (ratio_act == '0) begin
            base.lvl = 1'b1;
        end else begin
            base.lvl = ({1'b0, cnt_q} < high_len);
        end
    end

endmodule

// File: rtl/clkdiv_phase_dly.sv
module clkdiv_phase_dly
    import clkdiv_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              realign,
    input  logic [CODE_W-1:0] phase_act,
    input  wave_t             base_in,
    output wave_t             wave_out
);

    localparam int DEPTH = (1 << CODE_W) - 1;

    wave_t stage_q [DEPTH];
    wave_t tap;

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst || realign) begin
                stage_q[k] <= WAVE_IDLE;
            end else if (k == 0) begin
                stage_q[k] <= base_in;
            end else begin
                stage_q[k] <= stage_q[(k == 0) ? 0 : k - 1];
            end
        end
    end

    always_comb begin
        tap = base_in;
        for (int k = 0; k < DEPTH; k++) begin
            if (phase_act == CODE_W'(k + 1)) begin
                tap = stage_q[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || realign) begin
            wave_out <= WAVE_IDLE;
        end else begin
            wave_out <= tap;
        end
    end

endmodule

// File: rtl/clkdiv_phase_top.sv
module clkdiv_phase_top
    import clkdiv_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              realign,
    input  logic [CODE_W-1:0] ratio_code,
    input  logic [CODE_W-1:0] phase_code,
    input  logic              user_stab_en,
    output logic              div_clk,
    output logic              edge_pulse,
    output logic              stab_active
);

    logic [CODE_W-1:0] ratio_act;
    logic [CODE_W-1:0] phase_act;
    wave_t             base;
    wave_t             wave;

    clkdiv_cfg_hold #(.CODE_W(CODE_W)) cfg_i (
        .clk       (clk),
        .rst       (rst),
        .realign   (realign),
        .ratio_in  (ratio_code),
        .phase_in  (phase_code),
        .ratio_act (ratio_act),
        .phase_act (phase_act)
    );

    clkdiv_count #(.CODE_W(CODE_W)) cnt_i (
        .clk       (clk),
        .rst       (rst),
        .realign   (realign),
        .ratio_act (ratio_act),
        .base      (base)
    );

    clkdiv_phase_dly #(.CODE_W(CODE_W)) dly_i (
        .clk       (clk),
        .rst       (rst),
        .realign   (realign),
        .phase_act (phase_act),
        .base_in   (base),
        .wave_out  (wave)
    );

    assign div_clk     = wave.lvl;
    assign edge_pulse  = wave.edg;
    // Any division other than 1 forces the stabilizer request (R8).
    assign stab_active = user_stab_en || (ratio_act != '0);

endmodule

// File: rtl/clkdiv_phase_chk.sv
module clkdiv_phase_chk #(
    parameter int CODE_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              realign,
    input logic              user_stab_en,
    input logic              div_clk,
    input logic              edge_pulse,
    input logic              stab_active,
    input logic [CODE_W-1:0] ratio_act
);

    p_pulse_in_high_r4: assert property (@(posedge clk) disable iff (rst)
        edge_pulse |-> div_clk);

    p_pulse_spacing_r1: assert property (@(posedge clk) disable iff (rst)
        (edge_pulse && (ratio_act != '0) && !realign) |=> !edge_pulse);

    p_realign_low_r6: assert property (@(posedge clk) disable iff (rst)
        realign |=> (!div_clk && !edge_pulse));

    p_hold_cfg_r5: assert property (@(posedge clk) disable iff (rst)
        !realign |=> $stable(ratio_act));

    p_stab_forced_r8: assert property (@(posedge clk) disable iff (rst)
        (ratio_act != '0) |-> stab_active);

    p_stab_user_r8: assert property (@(posedge clk) disable iff (rst)
        user_stab_en |-> stab_active);

    always_ff @(posedge clk) begin
        if (!rst && $past(rst)) begin
            // R7: cycle after a reset edge shows an idle waveform.
            a_reset_idle_r7: assert (!div_clk && !edge_pulse);
        end
    end

endmodule

bind clkdiv_phase_top clkdiv_phase_chk #(.CODE_W(CODE_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .realign      (realign),
    .user_stab_en (user_stab_en),
    .div_clk      (div_clk),
    .edge_pulse   (edge_pulse),
    .stab_active  (stab_active),
    .ratio_act    (ratio_act)
);

// File: tb/clkdiv_phase_top_tb_top.sv
`timescale 1ns/1ps
module clkdiv_phase_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       realign = 1'b0;
    logic [2:0] ratio_code = 3'd0;
    logic [2:0] phase_code = 3'd0;
    logic       user_stab_en = 1'b1;
    logic       div_clk, edge_pulse, stab_active;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model: cycle index since last load edge, active division, delay.
    int mc = 0;
    int mn = 1;
    int mp = 0;

    always #5 clk = ~clk;

    clkdiv_phase_top dut_i (
        .clk(clk), .rst(rst), .realign(realign),
        .ratio_code(ratio_code), .phase_code(phase_code),
        .user_stab_en(user_stab_en),
        .div_clk(div_clk), .edge_pulse(edge_pulse), .stab_active(stab_active)
    );

    task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b (cycle %0d, N=%0d, p=%0d)",
                     tag, what, act, exp, mc, mn, mp);
        end
    endtask

    // Compare outputs for the current cycle, then apply rst/realign for the next edge.
    task automatic step(input bit do_rst, input bit do_re, input string tag);
        bit ed, ee;
        int m;
        @(negedge clk);
        if (mc < mp + 1) begin
            ed = 0; ee = 0;
        end else begin
            m = mc - 1 - mp;
            if (mn == 1) begin
                ed = 1; ee = 1;
            end else begin
                ed = (m % mn) < (mn / 2);
                ee = (m % mn) == 0;
            end
        end
        check_bit(tag, "div_clk", div_clk, ed);
        check_bit({tag, " R4"}, "edge_pulse", edge_pulse, ee);
        check_bit("R8", "stab_active", stab_active, user_stab_en || (mn != 1));
        rst = do_rst;
        realign = do_re;
        if (do_rst) begin
            mc = 0; mn = 1; mp = 0;
        end else if (do_re) begin
            mc = 0; mn = int'(ratio_code) + 1; mp = int'(phase_code);
        end else begin
            mc++;
        end
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, tag);
    endtask

    task automatic load(input int r, input int p, input string tag);
        ratio_code = 3'(r);
        phase_code = 3'(p);
        step(0, 1, tag);
    endtask

    initial begin
        // R7: reset held; outputs idle, divide-by-1 active.
        step(1, 0, "R7");
        step(1, 0, "R7");
        step(0, 0, "R7");
        run(6, "R2 R3 R7");

        // R1 R2 R3: every ratio and phase pair against the model.
        for (int r = 0; r < 8; r++) begin
            for (int p = 0; p < 8; p++) begin
                load(r, p, "R6");
                run(2 * (r + 1) + p + 3, "R1 R2 R3");
            end
        end

        // R5: code pins change without realign; waveform and flag keep the old setting.
        user_stab_en = 1'b0;
        load(0, 2, "R6");
        run(5, "R3");
        ratio_code = 3'd5;
        phase_code = 3'd6;
        run(12, "R5");
        load(5, 6, "R6");
        run(20, "R1 R3");

        // R6: realign in the middle of a period restarts it.
        load(6, 1, "R6");
        run(4, "R1");
        load(6, 1, "R6");
        run(16, "R6");

        // R8: user bit with divide-by-1 and with a forced ratio.
        load(0, 0, "R8");
        run(3, "R8");
        user_stab_en = 1'b1;
        run(3, "R8");
        user_stab_en = 1'b0;
        load(3, 0, "R8");
        run(6, "R8");

        // R7: reset during activity returns to divide-by-1, no delay.
        load(4, 3, "R6");
        run(5, "R1");
        ratio_code = 3'd2;
        phase_code = 3'd4;
        step(1, 0, "R7");
        step(0, 0, "R7");
        run(8, "R7");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule